// File: doc/BRIEF.md
# Event Interrupt and Bus-Hold Reset Controller

This block collects single-cycle event pulses from the accessory detection logic. It keeps them as sticky flags in two interrupt registers, and a register read clears them. Each flag has a mask bit. A global mask bit in a control register covers all of them. An active-low interrupt line tells the host that an unmasked flag is pending. The host reads the flag registers through the register interface of the bus target, and each read clears the register it returns.

The block also watches the synchronized serial clock and data lines of the host bus. If both lines stay low for longer than a fixed time, it issues a one-cycle digital reset pulse to the other digital blocks and resets its own registers. After such a reset, the interrupt line stays asserted until the host writes the global mask bit to zero.

The register interface is plain strobes and has no back-pressure. A read strobe is always served, and its data appears with a valid flag on the next cycle. A write strobe always takes effect at the clock edge that samples it.

Top module: `irq_hold_ctrl`

## Requirements
- R1: After the hardware reset, `irq_n` is 1, `soft_rst` is 0, the control register at 02h reads 01h, and both flag registers and both mask registers read 00h.
- R2: An event pulse sets its flag at the clock edge that samples it, and the flag stays set. Group 1 (register 03h) has bit 0 for attach and bit 1 for detach. Group 2 (register 04h) has bit 0 for charger-with-A/V-cable, bit 1 for reserved-device attach and bit 2 for ADC change.
- R3: A read strobe returns the addressed register on `rd_data` with `rd_valid` = 1 on the next cycle. A read of 03h or 04h clears that register. Bits with no flag read as 0.
- R4: If an event pulse arrives in the same cycle as a clearing read of its register, the read returns the old value and the flag is set afterwards.
- R5: `irq_n` is 0 when the global mask is 0 and a flag is set whose mask bit is 0. Mask register 05h covers group 1 and 06h covers group 2, with the same bit positions as the flags; a mask bit of 1 suppresses its flag. Otherwise `irq_n` is 1, unless R8 holds it low.
- R6: Bit 0 of 02h is the global mask. It is writable and readable, and 1 masks all flags. Writes to 03h and 04h change nothing.
- R7: If `scl_in` and `sda_in` are both low for HOLD+1 consecutive cycles, `soft_rst` goes to 1 for exactly one cycle, in the cycle after the last of those low cycles. If either line is low for only HOLD cycles, no pulse occurs. A cycle with either line high restarts the count. A hold that continues gives no second pulse.
- R8: The `soft_rst` pulse returns flags, masks and control to their R1 values. From the next cycle on, `irq_n` is 0 regardless of masks, until a write to 02h with bit 0 = 0. A write with bit 0 = 1 does not release it.
- R9: HOLD = CLK_HZ / 1000 * HOLD_MS cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| scl_in | input | 1 | Synchronized bus clock line |
| sda_in | input | 1 | Synchronized bus data line |
| evt_grp1 | input | 2 | Event pulses for group 1 (attach, detach) |
| evt_grp2 | input | 3 | Event pulses for group 2 (charger-A/V, reserved, ADC change) |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| irq_n | output | 1 | Active-low interrupt to host |
| soft_rst | output | 1 | One-cycle digital reset pulse |

## Verification
Flags, masks, the control bit and the interrupt line all change at the edge that samples the event or write strobe. Read data is due one cycle after the strobe. The reset pulse is due one cycle after the (HOLD+1)th low cycle, and `irq_n` shows the held state one cycle after that. The bench drives stimulus on the falling edge and samples on a later falling edge. It pushes each expected read value into a queue when it issues the strobe. A monitor pops the queue whenever `rd_valid` is seen and counts reset pulses, so that the hold lengths of HOLD and HOLD+1 are told apart exactly.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int N_GRP1 = 2;
  localparam int N_GRP2 = 3;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam logic [AW-1:0] A_CTRL  = 8'h02;
  localparam logic [AW-1:0] A_FLAG1 = 8'h03;
  localparam logic [AW-1:0] A_FLAG2 = 8'h04;
  localparam logic [AW-1:0] A_MASK1 = 8'h05;
  localparam logic [AW-1:0] A_MASK2 = 8'h06;
endpackage

// File: rtl/bus_hold_det.sv
module bus_hold_det #(
  parameter int CLK_HZ  = 125_000_000,
  parameter int HOLD_MS = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic pulse
);
  localparam int HOLD_CYC = CLK_HZ / 1000 * HOLD_MS;
  localparam int CW = $clog2(HOLD_CYC + 2);
  localparam logic [CW-1:0] LIM = CW'(HOLD_CYC);
  localparam logic [CW-1:0] SAT = CW'(HOLD_CYC + 1);

  logic both_low;
  logic [CW-1:0] cnt;

  assign both_low = ~scl_in & ~sda_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= both_low && (cnt == LIM);
      if (!both_low)
        cnt <= '0;
      else if (cnt != SAT)
        cnt <= cnt + 1'b1;
    end
  end

  // R7: a reset request lasts one cycle only
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
  // R7: a pulse is always preceded by both lines low
  a_r7_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse) |-> $past(both_low));
endmodule

// File: rtl/flag_bank.sv
module flag_bank #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         srst,
  input  logic [W-1:0] evt,
  input  logic         clr,
  output logic [W-1:0] flags
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        flags[i] <= 1'b0;
      else if (srst)
        flags[i] <= 1'b0;
      else if (evt[i])
        flags[i] <= 1'b1;
      else if (clr)
        flags[i] <= 1'b0;
    end

    // R2 / R4: an event always leaves its flag set, even against a clear
    a_r4_evt_sets: assert property (@(posedge clk) disable iff (!rst_n || srst)
      evt[i] |=> flags[i]);
    // R3: a clearing read with no new event empties the flag
    a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n || srst)
      (clr && !evt[i]) |=> !flags[i]);
    // R2: without event, clear or reset a flag keeps its value
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n || srst)
      (!clr && !evt[i]) |=> $stable(flags[i]));
  end
endmodule

// File: rtl/irq_hold_ctrl.sv
module irq_hold_ctrl
  import irqc_pkg::*;
#(
  parameter int CLK_HZ  = 125_000_000,
  parameter int HOLD_MS = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic [N_GRP1-1:0] evt_grp1,
  input  logic [N_GRP2-1:0] evt_grp2,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic              rd_valid,
  output logic              irq_n,
  output logic              soft_rst
);
  logic              srst;
  logic              gmask;
  logic              held;
  logic [N_GRP1-1:0] mask1, flag1;
  logic [N_GRP2-1:0] mask2, flag2;
  logic              clr1, clr2;
  logic [DW-1:0]     rd_mux;
  logic              pend;
  logic [DW-N_GRP2-1:0] unused_wr_hi;

  assign unused_wr_hi = wr_data[DW-1:N_GRP2];

  bus_hold_det #(.CLK_HZ(CLK_HZ), .HOLD_MS(HOLD_MS)) u_hold (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in), .pulse(srst)
  );
  assign soft_rst = srst;

  assign clr1 = rd_en && (rd_addr == A_FLAG1);
  assign clr2 = rd_en && (rd_addr == A_FLAG2);

  flag_bank #(.W(N_GRP1)) u_flag1 (
    .clk(clk), .rst_n(rst_n), .srst(srst), .evt(evt_grp1), .clr(clr1), .flags(flag1)
  );
  flag_bank #(.W(N_GRP2)) u_flag2 (
    .clk(clk), .rst_n(rst_n), .srst(srst), .evt(evt_grp2), .clr(clr2), .flags(flag2)
  );

  // control and mask registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gmask <= 1'b1;
      held  <= 1'b0;
      mask1 <= '0;
      mask2 <= '0;
    end else if (srst) begin
      gmask <= 1'b1;
      held  <= 1'b1;
      mask1 <= '0;
      mask2 <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          gmask <= wr_data[0];
          if (!wr_data[0]) held <= 1'b0;
        end
        A_MASK1: mask1 <= wr_data[N_GRP1-1:0];
        A_MASK2: mask2 <= wr_data[N_GRP2-1:0];
        default: ;
      endcase
    end
  end

  // read path
  always_comb begin
    rd_mux = '0;
    case (rd_addr)
      A_CTRL:  rd_mux[0] = gmask;
      A_FLAG1: rd_mux[N_GRP1-1:0] = flag1;
      A_FLAG2: rd_mux[N_GRP2-1:0] = flag2;
      A_MASK1: rd_mux[N_GRP1-1:0] = mask1;
      A_MASK2: rd_mux[N_GRP2-1:0] = mask2;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end

  assign pend  = (|(flag1 & ~mask1)) | (|(flag2 & ~mask2));
  assign irq_n = ~(held | (~gmask & pend));

  // R8: a bus-hold reset forces the interrupt line low on the next cycle
  a_r8_hold_after_srst: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> !irq_n);
  // R8: only a write of 0 to the global mask bit releases the held state
  a_r8_keep_held: assert property (@(posedge clk) disable iff (!rst_n || srst)
    (held && !(wr_en && wr_addr == A_CTRL && !wr_data[0])) |=> !irq_n);
  // R3: read data follows every strobe by exactly one cycle
  a_r3_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  a_r3_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  // R6: writing a flag register leaves its flags unchanged
  a_r6_ro_flag1: assert property (@(posedge clk) disable iff (!rst_n || srst)
    (wr_en && wr_addr == A_FLAG1 && evt_grp1 == '0 && !clr1) |=> $stable(flag1));
  // R5: globally masked and not held means no interrupt
  a_r5_gmask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (gmask && !held) |-> irq_n);
endmodule

// File: tb/irq_hold_ctrl_test.sv
`timescale 1ns/1ps
module irq_hold_ctrl_test;
  localparam int CLK_HZ  = 100_000;
  localparam int HOLD_MS = 1;
  localparam int HOLD    = CLK_HZ / 1000 * HOLD_MS;   // R9

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_in = 1'b1, sda_in = 1'b1;
  logic [1:0] evt_grp1 = '0;
  logic [2:0] evt_grp2 = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
  logic [7:0] rd_data;
  logic       rd_valid, irq_n, soft_rst;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  bit done   = 1'b0;

  logic [7:0] q_exp[$];
  string      q_tag[$];

  always #4 clk = ~clk;   // 125 MHz

  irq_hold_ctrl #(.CLK_HZ(CLK_HZ), .HOLD_MS(HOLD_MS)) uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .evt_grp1(evt_grp1), .evt_grp2(evt_grp2),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_valid(rd_valid), .irq_n(irq_n), .soft_rst(soft_rst)
  );

  task automatic chk(input int got, input int exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // monitor: scoreboard for reads, counter for reset pulses
  always @(negedge clk) begin
    if (soft_rst === 1'b1) pulses++;
    if (rd_valid === 1'b1) begin
      if (q_exp.size() == 0) begin
        checks++; fails++;
        $display("FAIL R3: unexpected rd_valid, got %0h expected none", rd_data);
      end else begin
        chk(rd_data, q_exp.pop_front(), q_tag.pop_front());
      end
    end
  end

  task automatic do_read(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    q_exp.push_back(exp); q_tag.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_evt(input logic [1:0] e1, input logic [2:0] e2);
    @(negedge clk);
    evt_grp1 = e1; evt_grp2 = e2;
    @(negedge clk);
    evt_grp1 = '0; evt_grp2 = '0;
  endtask

  task automatic hold_low(input int n);
    @(negedge clk);
    scl_in = 1'b0; sda_in = 1'b0;
    repeat (n) @(negedge clk);
    scl_in = 1'b1; sda_in = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(irq_n, 1, "R1 irq_n after reset");
    chk(pulses, 0, "R1 no soft_rst after reset");
    do_read(8'h02, 8'h01, "R1 control reset value");
    do_read(8'h03, 8'h00, "R1 flag1 reset value");
    do_read(8'h06, 8'h00, "R1 mask2 reset value");

    // R2/R3 attach flag, read, clear; R5 global mask keeps irq quiet
    pulse_evt(2'b01, 3'b000);
    chk(irq_n, 1, "R5 global mask suppresses irq");
    do_read(8'h03, 8'h01, "R2 attach flag bit0");
    do_read(8'h03, 8'h00, "R3 flag1 cleared by read");

    // R6 global mask cleared; R5 irq from group 2
    do_write(8'h02, 8'h00);
    do_read(8'h02, 8'h00, "R6 control readback");
    pulse_evt(2'b00, 3'b101);
    chk(irq_n, 0, "R5 irq on unmasked group2 flags");
    do_read(8'h04, 8'h05, "R2 charger-AV and ADC flags");
    chk(irq_n, 1, "R5 irq released after clearing read");

    // R5 per-flag mask
    do_write(8'h05, 8'h02);
    pulse_evt(2'b10, 3'b000);
    chk(irq_n, 1, "R5 masked detach gives no irq");
    do_read(8'h05, 8'h02, "R5 mask1 readback");
    do_read(8'h03, 8'h02, "R2 detach flag bit1 still recorded");
    do_write(8'h05, 8'h00);

    // R4 event in the same cycle as the clearing read
    pulse_evt(2'b01, 3'b000);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = 8'h03; evt_grp1 = 2'b01;
    q_exp.push_back(8'h01); q_tag.push_back("R4 read returns old value");
    @(negedge clk);
    rd_en = 1'b0; evt_grp1 = '0;
    chk(irq_n, 0, "R4 flag survives clearing read");
    do_read(8'h03, 8'h01, "R4 flag still set after read");
    do_read(8'h03, 8'h00, "R3 flag cleared by second read");

    // R6 read-only flag registers
    pulse_evt(2'b00, 3'b010);
    do_write(8'h04, 8'h00);
    do_write(8'h03, 8'hFF);
    do_read(8'h03, 8'h00, "R6 write to 03h ignored");
    chk(irq_n, 0, "R6 reserved flag kept despite write");

    // R7 bus-hold detection boundaries
    do_write(8'h06, 8'h04);
    hold_low(HOLD);
    chk(pulses, 0, "R7 HOLD low cycles give no reset");
    @(negedge clk);
    scl_in = 1'b0; sda_in = 1'b0;
    repeat (HOLD) @(negedge clk);
    scl_in = 1'b1;
    @(negedge clk);
    scl_in = 1'b0;
    repeat (HOLD) @(negedge clk);
    scl_in = 1'b1; sda_in = 1'b1;
    repeat (3) @(negedge clk);
    chk(pulses, 0, "R7 high line restarts count");
    do_read(8'h04, 8'h02, "R7 no reset so flag2 kept");
    hold_low(HOLD + 1);
    chk(pulses, 1, "R7 HOLD+1 low cycles give one pulse");
    hold_low(2 * HOLD + 10);
    chk(pulses, 2, "R7 long hold gives a single pulse");

    // R8 state after soft reset
    chk(irq_n, 0, "R8 irq held low after soft reset");
    do_read(8'h02, 8'h01, "R8 control back to reset value");
    do_read(8'h06, 8'h00, "R8 mask2 back to zero");
    do_read(8'h04, 8'h00, "R8 flags cleared");
    do_write(8'h02, 8'h01);
    chk(irq_n, 0, "R8 writing mask 1 keeps irq held");
    do_write(8'h02, 8'h00);
    chk(irq_n, 1, "R8 writing mask 0 releases irq");

    repeat (3) @(negedge clk);
    chk(q_exp.size(), 0, "R3 every read answered");
    done = 1'b1;
    summary();
    $finish;
  end
endmodule